// File: doc/BRIEF.md
# Arithmetic-Group Opcode Decoder

This block looks at the first opcode byte of a 16-bit-era instruction stream and, when the instruction needs one, the ModR/M byte that follows. It turns them into the control word an ALU front end needs. For the eight two-operand arithmetic and logic operations, the control word holds:

- the operation to perform;
- the operand width;
- which side is written back;
- where the second operand comes from;
- whether the accumulator is the implicit operand;
- the base execution cycle count, with a flag that says whether effective-address time must be added.

The block serves two encodings. In the row encoding, the operation comes from the opcode byte. In the three immediate groups, the operation comes from the reg field of the ModR/M byte. Opcodes the block does not handle are flagged so that a neighbouring decoder can claim them. Two of these are segment-override prefixes, and for those the block also reports that they are prefixes and gives their cycle count.

The result is registered. A control word appears one clock after the opcode is presented with its valid strobe. The ModR/M byte may arrive late. Until it is marked present, the fields that depend on it are reported as not yet valid.

Top module: `arith_opdec`

## Requirements
- R1: For opcodes 0x00–0x3F whose low three bits are 0–5, `alu_op` equals opcode bits 5:3, with the encoding ADD=0, OR=1, ADC=2, SBB=3, AND=4, SUB=5, XOR=6, CMP=7. In these cases `alu_op_vld` is 1, whether or not a ModR/M byte is present.
- R2: For opcodes 0x80, 0x81 and 0x83, `alu_op` equals ModR/M bits 5:3, using the same encoding as R1. `alu_op_vld` is 1 only when `modrm_vld` is 1. Otherwise `alu_op` and `alu_op_vld` are both 0.
- R3: Row low bits 0 and 1 give `rm_dst`=1 and `src_sel`=0 (register source). `wide` equals opcode bit 0, where 0 means byte and 1 means word.
- R4: Row low bits 2 and 3 give `rm_dst`=0 and `src_sel`=0. `wide` equals opcode bit 0.
- R5: Row low bit pattern 4 gives `acc_implicit`=1, `src_sel`=1 (imm8) and `wide`=0. Row low bit pattern 5 gives `acc_implicit`=1, `src_sel`=2 (imm16) and `wide`=1. In both cases `needs_modrm`=0, `rm_dst`=0 and `base_cyc`=4 with `cyc_vld`=1.
- R6: All three groups set `rm_dst`=1. 0x80 gives `wide`=0 and `src_sel`=1. 0x81 gives `wide`=1 and `src_sel`=2. 0x83 gives `wide`=1 and `src_sel`=3 (imm8 sign-extended to 16 bits).
- R7: A ModR/M mod field (bits 7:6) of 3 means a register operand; any other value means memory. Row forms 0–3 with a register operand give `base_cyc`=3 and `plus_ea`=0. With a memory operand, an r/m destination gives `base_cyc`=24 and a register destination gives `base_cyc`=13, and `plus_ea`=1 in both cases.
- R8: The group forms give `base_cyc`=4 with a register operand and `base_cyc`=23 with a memory operand. With a memory operand `plus_ea`=1.
- R9: Opcodes 0x26 and 0x2E give `seg_prefix`=1, `not_arith`=1, `base_cyc`=2 and `cyc_vld`=1.
- R10: Row low bits 6 and 7, and every opcode outside 0x00–0x3F, 0x80, 0x81 and 0x83, give `not_arith`=1. For these opcodes every other field except `out_vld` is 0, apart from the prefix fields of R9.
- R11: `needs_modrm` is 1 for row low bits 0–3 and for the three groups. For these forms, `cyc_vld` equals `modrm_vld`. When `cyc_vld` is 0, `base_cyc` and `plus_ea` are 0.
- R12: The outputs reflect the inputs sampled at the previous rising clock edge, and `out_vld` follows `in_vld`. When `in_vld` is 0, every output is 0 one cycle later. After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | An opcode byte is presented this cycle |
| opcode | input | 8 | First opcode byte |
| modrm_vld | input | 1 | The ModR/M byte is present |
| modrm | input | 8 | ModR/M byte (mod 7:6, reg 5:3, r/m 2:0) |
| out_vld | output | 1 | Control word is valid |
| alu_op | output | 3 | Operation select |
| alu_op_vld | output | 1 | `alu_op` is known |
| wide | output | 1 | 1 = 16-bit operands, 0 = 8-bit |
| rm_dst | output | 1 | The r/m operand is the destination |
| src_sel | output | 2 | 0 register, 1 imm8, 2 imm16, 3 sign-extended imm8 |
| acc_implicit | output | 1 | Accumulator is the implicit operand |
| needs_modrm | output | 1 | Instruction carries a ModR/M byte |
| not_arith | output | 1 | Opcode is not handled here |
| seg_prefix | output | 1 | Opcode is a segment-override prefix |
| cyc_vld | output | 1 | `base_cyc` and `plus_ea` are known |
| base_cyc | output | CYC_W | Base cycle count |
| plus_ea | output | 1 | Add effective-address time to `base_cyc` |

## Verification
The hardest situation to reach is a group opcode whose ModR/M byte has not yet arrived. In that case the operation and cycle fields must stay invalid, while the width, source and destination fields are already reported. The stimulus presents each group opcode with `modrm_vld` low and a non-zero reg field on the ModR/M bus. It then presents the same opcode with the byte marked present, once for every reg value and with both register and memory mod fields. The stimulus also inserts idle cycles between opcodes, to show that the registered stage returns to zero.

// File: rtl/arith_dec_pkg.sv
package arith_dec_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_OR  = 3'd1,
        OP_ADC = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_SUB = 3'd5,
        OP_XOR = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_REG    = 2'd0,
        SRC_IMM8   = 2'd1,
        SRC_IMM16  = 2'd2,
        SRC_IMM8SX = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        FORM_NONE    = 3'd0,
        FORM_RM_DST  = 3'd1,
        FORM_REG_DST = 3'd2,
        FORM_ACC_IMM = 3'd3,
        FORM_GRP_IMM = 3'd4,
        FORM_PREFIX  = 3'd5
    } form_e;

    localparam logic [7:0] GRP_IMM8    = 8'h80;
    localparam logic [7:0] GRP_IMM16   = 8'h81;
    localparam logic [7:0] GRP_IMM8SX  = 8'h83;
    localparam logic [7:0] PFX_SEG_A   = 8'h26;
    localparam logic [7:0] PFX_SEG_B   = 8'h2E;

endpackage

// File: rtl/arith_row_dec.sv
module arith_row_dec
    import arith_dec_pkg::*;
(
    input  logic [7:0] opcode,
    output logic       hit,
    output form_e      form,
    output alu_op_e    op,
    output logic       wide,
    output src_e       src
);
    logic [2:0] low;

    always_comb begin
        low  = opcode[2:0];
        hit  = (opcode[7:6] == 2'b00) && (low < 3'd6);
        op   = alu_op_e'(opcode[5:3]);
        wide = opcode[0];
        src  = SRC_REG;
        form = FORM_NONE;
        if (hit) begin
            unique case (low[2:1])
                2'b00:   form = FORM_RM_DST;
                2'b01:   form = FORM_REG_DST;
                default: begin
                    form = FORM_ACC_IMM;
                    src  = low[0] ? SRC_IMM16 : SRC_IMM8;
                end
            endcase
        end
    end
endmodule

// File: rtl/arith_grp_dec.sv
module arith_grp_dec
    import arith_dec_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [7:0] modrm,
    output logic       hit,
    output alu_op_e    op,
    output logic       wide,
    output src_e       src
);
    always_comb begin
        hit  = 1'b0;
        src  = SRC_REG;
        op   = alu_op_e'(modrm[5:3]);
        wide = opcode[0];
        unique case (opcode)
            GRP_IMM8:   begin hit = 1'b1; src = SRC_IMM8;   end
            GRP_IMM16:  begin hit = 1'b1; src = SRC_IMM16;  end
            GRP_IMM8SX: begin hit = 1'b1; src = SRC_IMM8SX; end
            default:    begin hit = 1'b0; src = SRC_REG;    end
        endcase
    end
endmodule

// File: rtl/arith_cyc_calc.sv
module arith_cyc_calc
    import arith_dec_pkg::*;
#(
    parameter int CYC_W          = 5,
    parameter int CYC_REG        = 3,
    parameter int CYC_MEM_RMDST  = 24,
    parameter int CYC_MEM_REGDST = 13,
    parameter int CYC_ACC        = 4,
    parameter int CYC_GRP_REG    = 4,
    parameter int CYC_GRP_MEM    = 23,
    parameter int CYC_PREFIX     = 2
) (
    input  form_e            form,
    input  logic             modrm_vld,
    input  logic [1:0]       mod_field,
    output logic [CYC_W-1:0] cyc,
    output logic             cyc_vld,
    output logic             plus_ea
);
    localparam logic [1:0] MOD_REG = 2'b11;

    logic is_mem;

    always_comb begin
        is_mem  = (mod_field != MOD_REG);
        cyc     = '0;
        cyc_vld = 1'b0;
        plus_ea = 1'b0;
        unique case (form)
            FORM_RM_DST, FORM_REG_DST, FORM_GRP_IMM: begin
                cyc_vld = modrm_vld;
                if (modrm_vld) begin
                    plus_ea = is_mem;
                    if (form == FORM_GRP_IMM)
                        cyc = is_mem ? CYC_W'(CYC_GRP_MEM) : CYC_W'(CYC_GRP_REG);
                    else if (!is_mem)
                        cyc = CYC_W'(CYC_REG);
                    else if (form == FORM_RM_DST)
                        cyc = CYC_W'(CYC_MEM_RMDST);
                    else
                        cyc = CYC_W'(CYC_MEM_REGDST);
                end
            end
            FORM_ACC_IMM: begin
                cyc_vld = 1'b1;
                cyc     = CYC_W'(CYC_ACC);
            end
            FORM_PREFIX: begin
                cyc_vld = 1'b1;
                cyc     = CYC_W'(CYC_PREFIX);
            end
            default: begin
                cyc_vld = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/arith_opdec.sv
module arith_opdec
    import arith_dec_pkg::*;
#(
    parameter int CYC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [7:0]       opcode,
    input  logic             modrm_vld,
    input  logic [7:0]       modrm,
    output logic             out_vld,
    output logic [2:0]       alu_op,
    output logic             alu_op_vld,
    output logic             wide,
    output logic             rm_dst,
    output logic [1:0]       src_sel,
    output logic             acc_implicit,
    output logic             needs_modrm,
    output logic             not_arith,
    output logic             seg_prefix,
    output logic             cyc_vld,
    output logic [CYC_W-1:0] base_cyc,
    output logic             plus_ea
);
    typedef struct packed {
        logic             vld;
        alu_op_e          op;
        logic             op_vld;
        logic             wide;
        logic             rm_dst;
        src_e             src;
        logic             acc;
        logic             needs;
        logic             na;
        logic             pfx;
        logic             cvld;
        logic [CYC_W-1:0] cyc;
        logic             ea;
    } dec_t;

    logic    row_hit, grp_hit, row_wide, grp_wide;
    form_e   row_form, form;
    alu_op_e row_op, grp_op;
    src_e    row_src, grp_src;
    logic [CYC_W-1:0] calc_cyc;
    logic    calc_cvld, calc_ea;
    dec_t    dec_d, dec_q;

    arith_row_dec u_row (
        .opcode (opcode),
        .hit    (row_hit),
        .form   (row_form),
        .op     (row_op),
        .wide   (row_wide),
        .src    (row_src)
    );

    arith_grp_dec u_grp (
        .opcode (opcode),
        .modrm  (modrm),
        .hit    (grp_hit),
        .op     (grp_op),
        .wide   (grp_wide),
        .src    (grp_src)
    );

    always_comb begin
        if (row_hit)
            form = row_form;
        else if (grp_hit)
            form = FORM_GRP_IMM;
        else if (opcode == PFX_SEG_A || opcode == PFX_SEG_B)
            form = FORM_PREFIX;
        else
            form = FORM_NONE;
    end

    arith_cyc_calc #(.CYC_W(CYC_W)) u_cyc (
        .form      (form),
        .modrm_vld (modrm_vld),
        .mod_field (modrm[7:6]),
        .cyc       (calc_cyc),
        .cyc_vld   (calc_cvld),
        .plus_ea   (calc_ea)
    );

    always_comb begin
        dec_d = '0;
        if (in_vld) begin
            dec_d.vld  = 1'b1;
            dec_d.cvld = calc_cvld;
            dec_d.cyc  = calc_cyc;
            dec_d.ea   = calc_ea;
            unique case (form)
                FORM_RM_DST, FORM_REG_DST, FORM_ACC_IMM: begin
                    dec_d.op     = row_op;
                    dec_d.op_vld = 1'b1;
                    dec_d.wide   = row_wide;
                    dec_d.src    = row_src;
                    dec_d.rm_dst = (form == FORM_RM_DST);
                    dec_d.acc    = (form == FORM_ACC_IMM);
                    dec_d.needs  = (form != FORM_ACC_IMM);
                end
                FORM_GRP_IMM: begin
                    dec_d.op_vld = modrm_vld;
                    dec_d.op     = modrm_vld ? grp_op : OP_ADD;
                    dec_d.wide   = grp_wide;
                    dec_d.src    = grp_src;
                    dec_d.rm_dst = 1'b1;
                    dec_d.needs  = 1'b1;
                end
                FORM_PREFIX: begin
                    dec_d.na  = 1'b1;
                    dec_d.pfx = 1'b1;
                end
                default: begin
                    dec_d.na = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dec_q <= '0;
        else
            dec_q <= dec_d;
    end

    assign out_vld      = dec_q.vld;
    assign alu_op       = dec_q.op;
    assign alu_op_vld   = dec_q.op_vld;
    assign wide         = dec_q.wide;
    assign rm_dst       = dec_q.rm_dst;
    assign src_sel      = dec_q.src;
    assign acc_implicit = dec_q.acc;
    assign needs_modrm  = dec_q.needs;
    assign not_arith    = dec_q.na;
    assign seg_prefix   = dec_q.pfx;
    assign cyc_vld      = dec_q.cvld;
    assign base_cyc     = dec_q.cyc;
    assign plus_ea      = dec_q.ea;
endmodule

// File: rtl/arith_opdec_chk.sv
module arith_opdec_chk #(
    parameter int CYC_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic             modrm_vld,
    input logic             out_vld,
    input logic             alu_op_vld,
    input logic             wide,
    input logic             rm_dst,
    input logic [1:0]       src_sel,
    input logic             acc_implicit,
    input logic             needs_modrm,
    input logic             not_arith,
    input logic             cyc_vld,
    input logic [CYC_W-1:0] base_cyc,
    input logic             plus_ea
);
    // R12: one-cycle registered stage
    p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_vld == $past(in_vld)));

    // R10: unhandled opcodes carry no arithmetic control
    p_noarith_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && not_arith) |-> (!needs_modrm && !acc_implicit && !alu_op_vld
                                    && src_sel == 2'd0 && !rm_dst && !plus_ea));

    // R5: accumulator forms are immediate, no ModR/M, four cycles
    p_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_implicit |-> (!needs_modrm && !rm_dst && src_sel != 2'd0
                          && cyc_vld && base_cyc == CYC_W'(4)));

    // R7: address time only for ModR/M forms with a memory operand
    p_ea_r7: assert property (@(posedge clk) disable iff (!rst_n)
        plus_ea |-> (needs_modrm && cyc_vld && (base_cyc == CYC_W'(13)
                     || base_cyc == CYC_W'(23) || base_cyc == CYC_W'(24))));

    // R11: cycle count withheld until the ModR/M byte is present
    p_modrm_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_vld && needs_modrm && !$past(modrm_vld)) |-> !cyc_vld);

    // R2: group operation withheld until the ModR/M byte is present
    p_grp_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_vld && rm_dst && src_sel != 2'd0 && !$past(modrm_vld))
        |-> !alu_op_vld);

    // R6: sign-extended immediate only on word operations
    p_sx_wide_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'd3) |-> (wide && rm_dst));
endmodule

bind arith_opdec arith_opdec_chk #(.CYC_W(CYC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_vld       (in_vld),
    .modrm_vld    (modrm_vld),
    .out_vld      (out_vld),
    .alu_op_vld   (alu_op_vld),
    .wide         (wide),
    .rm_dst       (rm_dst),
    .src_sel      (src_sel),
    .acc_implicit (acc_implicit),
    .needs_modrm  (needs_modrm),
    .not_arith    (not_arith),
    .cyc_vld      (cyc_vld),
    .base_cyc     (base_cyc),
    .plus_ea      (plus_ea)
);

// File: tb/tb_arith_opdec.sv
`timescale 1ns/1ps
module tb_arith_opdec;
    localparam int CYC_W = 5;
    localparam int VW    = 15 + CYC_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0, modrm_vld = 1'b0;
    logic [7:0] opcode = 8'h0, modrm = 8'h0;
    logic out_vld, alu_op_vld, wide, rm_dst, acc_implicit, needs_modrm;
    logic not_arith, seg_prefix, cyc_vld, plus_ea;
    logic [2:0] alu_op;
    logic [1:0] src_sel;
    logic [CYC_W-1:0] base_cyc;

    int n_chk = 0;
    int n_bad = 0;
    logic [VW-1:0] exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    arith_opdec #(.CYC_W(CYC_W)) dut (.*);

    function automatic logic [VW-1:0] got_vec();
        return {out_vld, alu_op, alu_op_vld, wide, rm_dst, src_sel, acc_implicit,
                needs_modrm, not_arith, seg_prefix, cyc_vld, base_cyc, plus_ea};
    endfunction

    // Reference built from the requirement list
    function automatic logic [VW-1:0] model(input logic iv, input logic [7:0] o,
                                            input logic mv, input logic [7:0] m);
        logic [2:0] op = 0; logic opv = 0, w = 0, rd = 0, acc = 0, nm = 0;
        logic na = 0, sp = 0, cv = 0, ea = 0; logic [1:0] s = 0;
        logic [CYC_W-1:0] c = 0; logic mem;
        if (!iv) return '0;
        mem = (m[7:6] != 2'b11);
        if (o[7:6] == 2'b00 && o[2:0] < 3'd6) begin
            op = o[5:3]; opv = 1; w = o[0];
            if (o[2:1] == 2'b10) begin
                acc = 1; s = o[0] ? 2'd2 : 2'd1; cv = 1; c = 4;
            end else begin
                nm = 1; rd = (o[2:1] == 2'b00); cv = mv; ea = mv && mem;
                if (mv) c = !mem ? 5'd3 : (rd ? 5'd24 : 5'd13);
            end
        end else if (o == 8'h80 || o == 8'h81 || o == 8'h83) begin
            nm = 1; rd = 1; w = o[0];
            s = (o == 8'h80) ? 2'd1 : (o == 8'h81) ? 2'd2 : 2'd3;
            opv = mv; op = mv ? m[5:3] : 3'd0; cv = mv; ea = mv && mem;
            if (mv) c = mem ? 5'd23 : 5'd4;
        end else if (o == 8'h26 || o == 8'h2E) begin
            na = 1; sp = 1; cv = 1; c = 2;
        end else begin
            na = 1;
        end
        return {1'b1, op, opv, w, rd, s, acc, nm, na, sp, cv, c, ea};
    endfunction

    task automatic drive(input logic iv, input logic [7:0] o, input logic mv,
                         input logic [7:0] m, input string tag);
        @(negedge clk);
        in_vld = iv; opcode = o; modrm_vld = mv; modrm = m;
        exp_q.push_back(model(iv, o, mv, m));
        tag_q.push_back(tag);
    endtask

    // Monitor: compare one item per cycle, just after the edge
    initial begin
        forever begin
            @(posedge clk); #1;
            if (exp_q.size() > 0) begin
                logic [VW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (got_vec() !== e) begin
                    n_bad++;
                    $display("FAIL %s op=%h: got %h expected %h", t, opcode, got_vec(), e);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #20;
        n_chk++;
        if (got_vec() !== '0) begin
            n_bad++;
            $display("FAIL R12 reset: got %h expected %h", got_vec(), {VW{1'b0}});
        end
        @(negedge clk); rst_n = 1'b1;

        // Row opcodes, register operand: R1 R3 R4 R5 R9 R10
        for (int i = 0; i < 64; i++) begin
            string t;
            case (i % 8)
                0, 1:    t = "R1/R3";
                2, 3:    t = "R1/R4";
                4, 5:    t = "R1/R5";
                default: t = "R9/R10";
            endcase
            drive(1'b1, 8'(i), 1'b1, 8'hC0 | 8'(i % 8), t);
        end
        // Row ModR/M forms, memory operand: R7
        for (int i = 0; i < 8; i++)
            for (int l = 0; l < 4; l++)
                drive(1'b1, 8'(i * 8 + l), 1'b1, 8'h46, "R7");
        // Row ModR/M forms awaiting ModR/M: R11
        for (int l = 0; l < 4; l++)
            drive(1'b1, 8'(8 * l + l), 1'b0, 8'h06, "R11");
        // Idle gap: R12
        drive(1'b0, 8'h01, 1'b1, 8'hC0, "R12");
        drive(1'b0, 8'h81, 1'b1, 8'h06, "R12");
        // Groups, every reg field, register and memory: R2 R6 R8
        foreach (tag_q[k]) ;
        for (int g = 0; g < 3; g++) begin
            logic [7:0] gop;
            gop = (g == 0) ? 8'h80 : (g == 1) ? 8'h81 : 8'h83;
            for (int r = 0; r < 8; r++) begin
                drive(1'b1, gop, 1'b1, 8'hC0 | 8'(r << 3) | 8'(r), "R2/R6/R8");
                drive(1'b1, gop, 1'b1, 8'(r << 3) | 8'h05, "R2/R8");
                drive(1'b1, gop, 1'b0, 8'h38 | 8'(r << 3), "R2/R11");
            end
        end
        // Outside the covered set: R10
        drive(1'b1, 8'h82, 1'b1, 8'hC8, "R10");
        drive(1'b1, 8'h40, 1'b1, 8'hC0, "R10");
        drive(1'b1, 8'h84, 1'b1, 8'hC0, "R10");
        drive(1'b1, 8'hFF, 1'b1, 8'h00, "R10");
        drive(1'b1, 8'h36, 1'b0, 8'h00, "R10");
        drive(1'b1, 8'h2E, 1'b0, 8'h00, "R9");
        drive(1'b0, 8'h00, 1'b0, 8'h00, "R12");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule